// File: doc/BRIEF.md
# Radix-4 Multiplier-Free Inner Product Unit

This block computes the output of an N-tap adaptive FIR filter. The output is the inner product of a window of delayed input samples with the current coefficient vector. It uses no multipliers. Each tap cuts its sample into two-bit digits. Each digit picks one multiple of that tap's coefficient: zero, one, two or three times the coefficient. The coefficient's triple is formed once per tap and shared by all digits. The top digit of a sample is read as signed, so negative samples come out right.

Terms of the same digit position from all taps are summed in one tree per digit. A single shift-add stage then merges the per-digit sums, each weighted by four to the power of its digit index. Columns below the kept window are never formed. Only a few guard bits below the output LSB survive. The shifted result is clamped to the output width. The block also returns the error, which is the desired sample minus the filter output, clamped to the same width. A coefficient-update unit uses this error.

The design has two pipeline stages. One register follows the digit trees and a second follows the merge. A valid flag travels alongside the data.

Top module: `radix4_inner_product`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first valid result, `y_valid` is 0 and `y_out` and `err_out` are 0.
- R2: `y_valid` equals `in_valid` delayed by exactly two clock cycles.
- R3: Each sample and each coefficient is signed two's complement. Tap i sits at bits [i*SW +: SW] of its bus. Sample digit k is bits [2k+1:2k]. It is unsigned for k < SW/2-1, and the top digit is signed (-2..1). Each term digit·w·4^k is floored by 2^T, where T = OUT_SHIFT-GUARD (3 by default), and the floored terms are summed over all taps and digits. The sum is then floored by 2^GUARD (16) and clamped to signed OUT_W bits. `y_out` is this value.
- R4: Negative samples are weighted correctly. With one tap at sample -64 and coefficient 64 and all others zero, `y_out` is -32.
- R5: A result above 2^(OUT_W-1)-1 gives `y_out` = 127. A result below -2^(OUT_W-1) gives -128.
- R6: `err_out` equals `desired_in` (signed, captured with the same valid) minus `y_out`, clamped to signed OUT_W bits.
- R7: A cycle with `in_valid` low changes neither `y_out` nor `err_out`, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks the sample, coefficient and desired inputs as valid |
| samples_in | input | NTAPS*SW | Delayed-sample window, tap i at [i*SW +: SW] |
| weights_in | input | NTAPS*WW | Coefficient vector, tap i at [i*WW +: WW] |
| desired_in | input | OUT_W | Desired sample for error forming |
| y_valid | output | 1 | Result valid, two cycles after `in_valid` |
| y_out | output | OUT_W | Truncated, clamped filter output |
| err_out | output | OUT_W | Clamped desired minus filter output |

## Verification
The output clamp and the error clamp can fire in the same cycle, and the two act on each other. The bench provokes this with every sample and coefficient at the negative extreme, so the filter output clamps high. It sets the desired value to the opposite extreme, so the error clamps low. It then repeats the case with the polarities mirrored. The bench judges both outputs in that cycle against its own arithmetic model. Near-exhaustive sample sweeps run across all taps and a ladder of coefficients, with bubbles of invalid input between results. These confirm that the digit selection, truncation and hold behaviour agree with the model.

// File: rtl/r4ip_pkg.sv
package r4ip_pkg;

  // Multiple of the coefficient picked by one two-bit digit.
  // A signed top digit maps codes 2 and 3 to -2 and -1.
  function automatic int digit_multiple(input int w, input int w3,
                                        input logic [1:0] d, input bit top);
    int m;
    case (d)
      2'd0:    m = 0;
      2'd1:    m = w;
      2'd2:    m = top ? -(w <<< 1) : (w <<< 1);
      default: m = top ? -w : w3;
    endcase
    return m;
  endfunction

  // Clamp to the range of a signed field of the given width.
  function automatic int clamp_signed(input int v, input int width);
    int hi;
    int lo;
    hi = (1 <<< (width - 1)) - 1;
    lo = -(1 <<< (width - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/r4ip_tap_gen.sv
module r4ip_tap_gen #(
  parameter int SW   = 8,
  parameter int WW   = 8,
  parameter int TRUNC = 3,
  parameter int PP_W = WW + 2,
  localparam int ND  = SW / 2
) (
  input  logic [SW-1:0]      sample,
  input  logic [WW-1:0]      weight,
  output logic [ND*PP_W-1:0] terms
);

  int w_i;
  int w3_i;

  always_comb begin
    w_i  = int'($signed(weight));
    w3_i = w_i + (w_i <<< 1);
  end

  for (genvar k = 0; k < ND; k++) begin : g_digit
    localparam int DROP = (TRUNC > 2 * k) ? (TRUNC - 2 * k) : 0;
    localparam bit TOP  = (k == ND - 1);
    int m;
    always_comb begin
      m = r4ip_pkg::digit_multiple(w_i, w3_i, sample[2*k+1:2*k], TOP);
      m = m >>> DROP;
      terms[k*PP_W +: PP_W] = m[PP_W-1:0];
    end
  end

endmodule

// File: rtl/r4ip_digit_sum.sv
module r4ip_digit_sum #(
  parameter int NTAPS = 4,
  parameter int PP_W  = 10,
  parameter int DS_W  = PP_W + $clog2(NTAPS) + 1
) (
  input  logic [NTAPS*PP_W-1:0] terms,
  output logic [DS_W-1:0]       sum
);

  int acc;

  always_comb begin
    acc = 0;
    for (int i = 0; i < NTAPS; i++)
      acc = acc + int'($signed(terms[i*PP_W +: PP_W]));
    sum = acc[DS_W-1:0];
  end

endmodule

// File: rtl/r4ip_combine.sv
module r4ip_combine #(
  parameter int ND    = 4,
  parameter int DS_W  = 13,
  parameter int TRUNC = 3,
  parameter int GUARD = 4,
  parameter int OUT_W = 8
) (
  input  logic [ND*DS_W-1:0] sums,
  input  logic [OUT_W-1:0]   desired,
  output logic [OUT_W-1:0]   y,
  output logic [OUT_W-1:0]   err,
  output logic               over_hi,
  output logic               over_lo
);

  localparam int YMAX = (1 <<< (OUT_W - 1)) - 1;
  localparam int YMIN = -(1 <<< (OUT_W - 1));

  int parts [ND];
  int total;
  int scaled;
  int y_i;
  int e_i;

  for (genvar k = 0; k < ND; k++) begin : g_weight
    localparam int SH = ((2 * k > TRUNC) ? 2 * k : TRUNC) - TRUNC;
    always_comb parts[k] = int'($signed(sums[k*DS_W +: DS_W])) <<< SH;
  end

  always_comb begin
    total = 0;
    for (int k = 0; k < ND; k++) total = total + parts[k];
    scaled  = total >>> GUARD;
    over_hi = scaled > YMAX;
    over_lo = scaled < YMIN;
    y_i     = r4ip_pkg::clamp_signed(scaled, OUT_W);
    e_i     = r4ip_pkg::clamp_signed(int'($signed(desired)) - y_i, OUT_W);
    y       = y_i[OUT_W-1:0];
    err     = e_i[OUT_W-1:0];
  end

endmodule

// File: rtl/radix4_inner_product.sv
module radix4_inner_product #(
  parameter int NTAPS     = 4,
  parameter int SW        = 8,
  parameter int WW        = 8,
  parameter int OUT_W     = 8,
  parameter int OUT_SHIFT = 7,
  parameter int GUARD     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [NTAPS*SW-1:0]   samples_in,
  input  logic [NTAPS*WW-1:0]   weights_in,
  input  logic [OUT_W-1:0]      desired_in,
  output logic                  y_valid,
  output logic [OUT_W-1:0]      y_out,
  output logic [OUT_W-1:0]      err_out
);

  localparam int ND    = SW / 2;
  localparam int TRUNC = OUT_SHIFT - GUARD;
  localparam int PP_W  = WW + 2;
  localparam int DS_W  = PP_W + $clog2(NTAPS) + 1;

  logic [NTAPS-1:0][ND*PP_W-1:0] tap_terms;
  logic [ND-1:0][NTAPS*PP_W-1:0] digit_terms;
  logic [ND-1:0][DS_W-1:0]       digit_sums;

  logic [ND-1:0][DS_W-1:0]       s1_sums;
  logic [OUT_W-1:0]              s1_desired;
  logic                          s1_valid;

  logic [OUT_W-1:0]              y_next;
  logic [OUT_W-1:0]              err_next;
  logic                          over_hi;
  logic                          over_lo;

  // Events brought out for the checker
  logic                          sat_hi;
  logic                          sat_lo;

  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    r4ip_tap_gen #(.SW(SW), .WW(WW), .TRUNC(TRUNC), .PP_W(PP_W)) u_gen (
      .sample (samples_in[i*SW +: SW]),
      .weight (weights_in[i*WW +: WW]),
      .terms  (tap_terms[i])
    );
    for (genvar k = 0; k < ND; k++) begin : g_route
      assign digit_terms[k][i*PP_W +: PP_W] = tap_terms[i][k*PP_W +: PP_W];
    end
  end

  for (genvar k = 0; k < ND; k++) begin : g_tree
    r4ip_digit_sum #(.NTAPS(NTAPS), .PP_W(PP_W), .DS_W(DS_W)) u_sum (
      .terms (digit_terms[k]),
      .sum   (digit_sums[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid   <= 1'b0;
      s1_sums    <= '0;
      s1_desired <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_sums    <= digit_sums;
        s1_desired <= desired_in;
      end
    end
  end

  r4ip_combine #(.ND(ND), .DS_W(DS_W), .TRUNC(TRUNC), .GUARD(GUARD),
                 .OUT_W(OUT_W)) u_merge (
    .sums    (s1_sums),
    .desired (s1_desired),
    .y       (y_next),
    .err     (err_next),
    .over_hi (over_hi),
    .over_lo (over_lo)
  );

  assign sat_hi = s1_valid && over_hi;
  assign sat_lo = s1_valid && over_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_valid <= 1'b0;
      y_out   <= '0;
      err_out <= '0;
    end else begin
      y_valid <= s1_valid;
      if (s1_valid) begin
        y_out   <= y_next;
        err_out <= err_next;
      end
    end
  end

endmodule

// File: rtl/r4ip_checker.sv
module r4ip_checker #(
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [OUT_W-1:0] desired_in,
  input logic             y_valid,
  input logic [OUT_W-1:0] y_out,
  input logic [OUT_W-1:0] err_out,
  input logic             sat_hi,
  input logic             sat_lo
);

  localparam logic [OUT_W-1:0] YMAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] YMIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!y_valid && y_out == '0 && err_out == '0));

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (y_valid == $past(in_valid, 2)));

  assert_clamp_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hi |=> (y_valid && y_out == YMAX));

  assert_clamp_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sat_lo |=> (y_valid && y_out == YMIN));

  assert_error_zero_y_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && y_valid && y_out == '0) |-> (err_out == $past(desired_in, 2)));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd1 && !y_valid) |-> ($stable(y_out) && $stable(err_out)));

endmodule

bind radix4_inner_product r4ip_checker #(.OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .desired_in (desired_in),
  .y_valid    (y_valid),
  .y_out      (y_out),
  .err_out    (err_out),
  .sat_hi     (sat_hi),
  .sat_lo     (sat_lo)
);

// File: tb/tb_radix4_inner_product.sv
module tb_radix4_inner_product;

  localparam int NT = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] samples_in;
  logic [31:0] weights_in;
  logic [7:0]  desired_in;
  logic        y_valid;
  logic [7:0]  y_out;
  logic [7:0]  err_out;

  int n_chk = 0;
  int n_fail = 0;

  // two-deep expectation pipe
  bit    pv [2];
  int    py [2];
  int    pe [2];
  string pt [2];
  int    cur_y = 0;
  int    cur_e = 0;

  always #5 clk = ~clk;

  radix4_inner_product dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .samples_in(samples_in), .weights_in(weights_in), .desired_in(desired_in),
    .y_valid(y_valid), .y_out(y_out), .err_out(err_out)
  );

  function automatic int lim8(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  // Arithmetic model: digit value times weight times 4^k, floored by 8,
  // summed, floored by 16, clamped.
  function automatic int model_y(input logic [31:0] xs, input logic [31:0] ws);
    int acc;
    acc = 0;
    for (int t = 0; t < NT; t++) begin
      int x;
      int w;
      x = int'($signed(xs[t*8 +: 8]));
      w = int'($signed(ws[t*8 +: 8]));
      for (int k = 0; k < 4; k++) begin
        int dg;
        int part;
        if (k == 3) dg = x >>> 6;
        else        dg = (x >>> (2 * k)) & 3;
        part = dg * w * (1 << (2 * k));
        acc  = acc + (part >>> 3);
      end
    end
    return lim8(acc >>> 4);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] xs, input logic [31:0] ws,
                      input logic [7:0] d, input string tag);
    int yv;
    @(negedge clk);
    chk(y_valid == pv[1], "R2", int'(y_valid), int'(pv[1]));
    if (pv[1]) begin
      cur_y = py[1];
      cur_e = pe[1];
      chk(int'($signed(y_out)) == cur_y, pt[1], int'($signed(y_out)), cur_y);
      chk(int'($signed(err_out)) == cur_e, "R6", int'($signed(err_out)), cur_e);
    end else begin
      chk(int'($signed(y_out)) == cur_y, "R7", int'($signed(y_out)), cur_y);
      chk(int'($signed(err_out)) == cur_e, "R7", int'($signed(err_out)), cur_e);
    end
    pv[1] = pv[0]; py[1] = py[0]; pe[1] = pe[0]; pt[1] = pt[0];
    yv    = model_y(xs, ws);
    pv[0] = v;
    py[0] = yv;
    pe[0] = lim8(int'($signed(d)) - yv);
    pt[0] = tag;
    in_valid   = v;
    samples_in = xs;
    weights_in = ws;
    desired_in = d;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    samples_in = '0;
    weights_in = '0;
    desired_in = '0;
    for (int i = 0; i < 2; i++) begin pv[i] = 0; py[i] = 0; pe[i] = 0; pt[i] = "R3"; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: quiet while in reset
    chk(y_valid == 1'b0, "R1", int'(y_valid), 0);
    chk(y_out == 8'd0, "R1", int'(y_out), 0);
    chk(err_out == 8'd0, "R1", int'(err_out), 0);
    rst_n = 1'b1;
    step(1'b0, 32'h5a5a_a5a5, 32'h1234_8765, 8'h33, "R1");
    step(1'b0, 32'hffff_ffff, 32'h8080_8080, 8'h80, "R1");
    @(negedge clk);
    chk(y_valid == 1'b0 && y_out == 8'd0 && err_out == 8'd0, "R1", int'(y_out), 0);

    // R4: negative sample, single tap
    step(1'b1, 32'h0000_00c0, 32'h0000_0040, 8'h00, "R4");
    step(1'b0, '0, '0, 8'h00, "R7");
    step(1'b0, '0, '0, 8'h00, "R7");
    // direct R4 check of the literal value
    chk(int'($signed(y_out)) == -32, "R4", int'($signed(y_out)), -32);

    // R5 and R6 together: both clamps in one cycle
    step(1'b1, 32'h8080_8080, 32'h8080_8080, 8'h80, "R5");
    step(1'b1, 32'h8080_8080, 32'h7f7f_7f7f, 8'h7f, "R5");
    step(1'b0, '0, '0, 8'h00, "R7");
    step(1'b0, '0, '0, 8'h00, "R7");

    // R7: bubbles carrying changing data
    step(1'b1, 32'h1122_3344, 32'h0a0b_0c0d, 8'h10, "R3");
    for (int i = 0; i < 6; i++)
      step(1'b0, $urandom, $urandom, 8'($urandom), "R7");

    // R3: near-exhaustive sample sweep, rotating tap, coefficient ladder
    for (int s = 0; s < 256; s++) begin
      for (int wi = 0; wi < 16; wi++) begin
        logic [31:0] xs;
        logic [31:0] ws;
        int tap;
        tap = (s + wi) % NT;
        xs = '0;
        ws = '0;
        xs[tap*8 +: 8] = 8'(s);
        ws[tap*8 +: 8] = 8'(wi * 17 - 128);
        step(1'b1, xs, ws, 8'(s * 3 + wi), "R3");
      end
    end

    // R3/R2/R7: random full vectors with random bubbles
    for (int i = 0; i < 1500; i++)
      step(($urandom % 10) < 7, $urandom, $urandom, 8'($urandom), "R3");

    step(1'b0, '0, '0, 8'h00, "R7");
    step(1'b0, '0, '0, 8'h00, "R7");
    step(1'b0, '0, '0, 8'h00, "R7");
    summary();
  end

endmodule